// File: doc/BRIEF.md
# Ordered Issue and Retire Queue

This block keeps in-flight operations of an out-of-order core in one circular queue. Each slot serves both as a reservation station and as a reorder-buffer entry. Operations enter at the tail in program order. Each one carries up to three source register names and up to two destination names. Each waits until every source is ready. Ready operations are offered to the execution lanes, oldest first, and each is offered only once. Results return on a broadcast bus. A result names the producing slot together with that slot's tag, which completes the producer. It also names a destination register, which wakes every waiting consumer of that register. The head slot retires once it has completed, and the queue hands out its destination names and sequence number.

Mispredicted work is removed with a squash that names the sequence number of the last operation to keep. Every younger slot is dropped, and the tag of each dropped slot is incremented. A late result that still carries the old tag therefore has no effect. An operation marked as an address computation for a memory access raises a wake pulse when it completes, so that a separate memory queue can proceed. DEPTH must be a power of two.

Top module: `ruu_queue`

## Requirements
- R1: After reset the queue is empty. disp_ready is 1, disp_slot and disp_seq are 0, and iss_valid, ret_valid and ea_wake are all 0.
- R2: An accepted dispatch (disp_valid=1, disp_ready=1, squash_valid=0) writes the slot shown on disp_slot and gives it the sequence number shown on disp_seq. Both values then advance by one. A newly written slot with all sources ready is offered for issue in the next cycle, on lane 0 if it is the oldest ready entry.
- R3: A source name of all ones (31 at the default width) means the source is unused, and that source is ready at dispatch. A source whose disp_src_rdy bit is set is also ready at dispatch. Every other source waits for an accepted broadcast whose wb_dst equals that name. An entry is offered for issue only once all three of its sources are ready.
- R4: Each cycle, up to ISSUE_W ready entries are offered. Lane 0 carries the oldest of them in program order, counted from the head across the wrap of the slot index. An offered entry is marked issued at that clock edge and is never offered again.
- R5: A broadcast is accepted only if wb_slot holds a live, issued entry whose tag equals wb_tag. When a broadcast is not accepted, it neither completes the entry nor wakes any source. Every squash adds one to the tag of each slot it removes, and iss_tag shows the current tag of the slot.
- R6: When the head entry has completed, ret_valid is 1 and ret_dst0, ret_dst1 and ret_seq show that entry's values. Entries retire strictly in program order, one per cycle. No entry retires while the head has not completed or while the queue is empty.
- R7: When DEPTH entries are live, disp_ready is 0. A dispatch attempted in that state changes nothing, and disp_seq stays where it was.
- R8: A squash whose squash_seq names a live entry removes every younger entry. The tail then points to the slot after that entry, and the next sequence number becomes squash_seq+1. A squash that names no live entry is ignored.
- R9: When a broadcast is accepted for an entry dispatched with disp_ea=1, ea_wake is 1 in that same cycle and ea_wake_seq shows the entry's sequence number.
- R10: When a dispatch has a source that matches an accepted broadcast in the same cycle, that source is ready at allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src | input | 3*REG_W | Three source names; source k is at [k*REG_W +: REG_W] |
| disp_src_rdy | input | 3 | Source k is already available |
| disp_dst0 | input | REG_W | First destination name, all ones if unused |
| disp_dst1 | input | REG_W | Second destination name, all ones if unused |
| disp_ea | input | 1 | Operation is a memory address computation |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_slot | output | IW | Slot that the next dispatch will fill |
| disp_seq | output | SEQ_W | Sequence number of the next dispatch |
| wb_valid | input | 1 | Result broadcast |
| wb_slot | input | IW | Producing slot |
| wb_tag | input | TAG_W | Tag that the producer had when it issued |
| wb_dst | input | REG_W | Register name to wake, all ones for none |
| iss_valid | output | ISSUE_W | Offered lanes, lane 0 oldest |
| iss_slot | output | ISSUE_W*IW | Slot per lane |
| iss_tag | output | ISSUE_W*TAG_W | Tag per lane |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence number per lane |
| ret_valid | output | 1 | Head entry retires |
| ret_dst0 | output | REG_W | Retiring first destination |
| ret_dst1 | output | REG_W | Retiring second destination |
| ret_seq | output | SEQ_W | Retiring sequence number |
| ea_wake | output | 1 | Address computation has completed |
| ea_wake_seq | output | SEQ_W | Its sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Sequence number of the last entry to keep |

## Verification
The wakeup path is tried with four kinds of broadcast. A name that no entry waits for shows that matching is exact. A single producer that wakes three waiting consumers plus one consumer dispatched in the same cycle separates oldest-first selection from bypass at allocation. A result that carries a tag made stale by a squash shows that tag filtering blocks both completion and wakeup. A wakeup that releases slots on both sides of the index wrap checks that age is counted from the head rather than by slot number. Results are returned out of order, and a scoreboard of expected retirements shows that completion order never changes retirement order, including across a fill to full and a squash.

// File: rtl/ruu_queue.sv
module ruu_queue #(
  parameter int DEPTH   = 8,
  parameter int REG_W   = 5,
  parameter int SEQ_W   = 6,
  parameter int TAG_W   = 4,
  parameter int ISSUE_W = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic [3*REG_W-1:0]       disp_src,
  input  logic [2:0]               disp_src_rdy,
  input  logic [REG_W-1:0]         disp_dst0,
  input  logic [REG_W-1:0]         disp_dst1,
  input  logic                     disp_ea,
  output logic                     disp_ready,
  output logic [IW-1:0]            disp_slot,
  output logic [SEQ_W-1:0]         disp_seq,
  input  logic                     wb_valid,
  input  logic [IW-1:0]            wb_slot,
  input  logic [TAG_W-1:0]         wb_tag,
  input  logic [REG_W-1:0]         wb_dst,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*IW-1:0]    iss_slot,
  output logic [ISSUE_W*TAG_W-1:0] iss_tag,
  output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  output logic                     ret_valid,
  output logic [REG_W-1:0]         ret_dst0,
  output logic [REG_W-1:0]         ret_dst1,
  output logic [SEQ_W-1:0]         ret_seq,
  output logic                     ea_wake,
  output logic [SEQ_W-1:0]         ea_wake_seq,
  input  logic                     squash_valid,
  input  logic [SEQ_W-1:0]         squash_seq
);
  localparam logic [REG_W-1:0] NONE = {REG_W{1'b1}};

  logic [IW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic [SEQ_W-1:0] nseq_q;

  logic [DEPTH-1:0]                  vld_q, queued_q, issued_q, done_q, ea_q;
  logic [DEPTH-1:0][2:0]             rdy_q;
  logic [DEPTH-1:0][2:0][REG_W-1:0]  src_q;
  logic [DEPTH-1:0][REG_W-1:0]       dst0_q, dst1_q;
  logic [DEPTH-1:0][SEQ_W-1:0]       seq_q;
  logic [DEPTH-1:0][TAG_W-1:0]       tag_q;

  logic [DEPTH-1:0]      vld_n, queued_n, issued_n, done_n, kill, alloc, iss_mask;
  logic [DEPTH-1:0][2:0] rdy_n;

  logic wb_hit, wake, disp_go, sq_go;
  logic [SEQ_W-1:0] sq_off;

  assign disp_ready  = cnt_q != CW'(DEPTH);
  assign disp_slot   = tail_q;
  assign disp_seq    = nseq_q;
  assign disp_go     = disp_valid && disp_ready && !squash_valid;
  assign wb_hit      = wb_valid && vld_q[wb_slot] && issued_q[wb_slot] && (tag_q[wb_slot] == wb_tag);
  assign wake        = wb_hit && (wb_dst != NONE);
  assign ea_wake     = wb_hit && ea_q[wb_slot];
  assign ea_wake_seq = seq_q[wb_slot];
  assign ret_valid   = (cnt_q != '0) && done_q[head_q];
  assign ret_dst0    = dst0_q[head_q];
  assign ret_dst1    = dst1_q[head_q];
  assign ret_seq     = seq_q[head_q];
  assign sq_off      = squash_seq - seq_q[head_q];
  assign sq_go       = squash_valid && (cnt_q != '0) && (32'(sq_off) < 32'(cnt_q));

  always_comb begin
    int n;
    logic [IW-1:0] idx;
    n = 0;
    iss_valid = '0;
    iss_slot  = '0;
    iss_tag   = '0;
    iss_seq   = '0;
    iss_mask  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + IW'(k);
      if (n < ISSUE_W && vld_q[idx] && queued_q[idx]) begin
        iss_valid[n]               = 1'b1;
        iss_slot[n*IW +: IW]       = idx;
        iss_tag[n*TAG_W +: TAG_W]  = tag_q[idx];
        iss_seq[n*SEQ_W +: SEQ_W]  = seq_q[idx];
        iss_mask[idx]              = 1'b1;
        n++;
      end
    end
  end

  always_comb begin
    logic [IW-1:0] rel;
    for (int i = 0; i < DEPTH; i++) begin
      rel      = IW'(i) - head_q;
      kill[i]  = sq_go && vld_q[i] && (32'(rel) > 32'(sq_off));
      alloc[i] = disp_go && (tail_q == IW'(i));
      if (alloc[i]) begin
        vld_n[i]    = 1'b1;
        issued_n[i] = 1'b0;
        done_n[i]   = 1'b0;
        for (int j = 0; j < 3; j++) begin
          rdy_n[i][j] = disp_src_rdy[j] || (disp_src[j*REG_W +: REG_W] == NONE) ||
                        (wake && disp_src[j*REG_W +: REG_W] == wb_dst);
        end
      end else begin
        vld_n[i]    = vld_q[i] && !kill[i] && !(ret_valid && head_q == IW'(i));
        issued_n[i] = issued_q[i] || iss_mask[i];
        done_n[i]   = done_q[i] || (wb_hit && wb_slot == IW'(i));
        for (int j = 0; j < 3; j++) begin
          rdy_n[i][j] = rdy_q[i][j] || (wake && src_q[i][j] == wb_dst);
        end
      end
      queued_n[i] = vld_n[i] && (&rdy_n[i]) && !issued_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      nseq_q   <= '0;
      vld_q    <= '0;
      queued_q <= '0;
      issued_q <= '0;
      done_q   <= '0;
      rdy_q    <= '0;
      tag_q    <= '0;
    end else begin
      head_q   <= head_q + IW'(ret_valid);
      cnt_q    <= (sq_go ? CW'(sq_off) + CW'(1) : cnt_q) - CW'(ret_valid) + CW'(disp_go);
      tail_q   <= sq_go ? IW'(head_q + IW'(sq_off) + IW'(1)) : tail_q + IW'(disp_go);
      nseq_q   <= sq_go ? squash_seq + SEQ_W'(1) : nseq_q + SEQ_W'(disp_go);
      vld_q    <= vld_n;
      queued_q <= queued_n;
      issued_q <= issued_n;
      done_q   <= done_n;
      rdy_q    <= rdy_n;
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i]) tag_q[i] <= tag_q[i] + TAG_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc[i]) begin
        for (int j = 0; j < 3; j++) src_q[i][j] <= disp_src[j*REG_W +: REG_W];
        dst0_q[i] <= disp_dst0;
        dst1_q[i] <= disp_dst1;
        seq_q[i]  <= nseq_q;
        ea_q[i]   <= disp_ea;
      end
    end
  end
endmodule

module ruu_queue_chk #(
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 6,
  parameter int ISSUE_W = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CW-1:0]            cnt_q,
  input logic [SEQ_W-1:0]         nseq_q,
  input logic                     disp_valid,
  input logic                     disp_ready,
  input logic                     squash_valid,
  input logic [SEQ_W-1:0]         squash_seq,
  input logic                     sq_go,
  input logic                     ret_valid,
  input logic [ISSUE_W-1:0]       iss_valid,
  input logic [ISSUE_W*IW-1:0]    iss_slot,
  input logic [DEPTH-1:0][2:0]    rdy_q,
  input logic [DEPTH-1:0]         issued_q
);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(cnt_q) <= DEPTH);
  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) == DEPTH) |=> (cnt_q <= $past(cnt_q)));
  // R6
  empty_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !ret_valid);
  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !squash_valid) |=> (nseq_q == $past(nseq_q) + SEQ_W'(1)));
  // R8
  squash_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_go |=> (nseq_q == $past(squash_seq) + SEQ_W'(1)));

  for (genvar w = 0; w < ISSUE_W; w++) begin : g_lane
    // R3
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[w] |-> (&rdy_q[iss_slot[w*IW +: IW]]));
    // R4
    issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[w] |=> issued_q[$past(iss_slot[w*IW +: IW])]);
  end
endmodule

bind ruu_queue ruu_queue_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .nseq_q(nseq_q),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .squash_valid(squash_valid), .squash_seq(squash_seq), .sq_go(sq_go),
  .ret_valid(ret_valid), .iss_valid(iss_valid), .iss_slot(iss_slot),
  .rdy_q(rdy_q), .issued_q(issued_q)
);

// File: tb/tb_ruu_queue.sv
module tb_ruu_queue;
  localparam int CLK_P = 10;
  localparam logic [4:0] NA = 5'd31;

  logic clk = 0, rst_n = 0;
  logic disp_valid, disp_ea, wb_valid, squash_valid;
  logic [14:0] disp_src;
  logic [2:0] disp_src_rdy;
  logic [4:0] disp_dst0, disp_dst1, wb_dst;
  logic [2:0] wb_slot;
  logic [3:0] wb_tag;
  logic [5:0] squash_seq;
  logic disp_ready, ret_valid, ea_wake;
  logic [2:0] disp_slot;
  logic [5:0] disp_seq, ret_seq, ea_wake_seq;
  logic [1:0] iss_valid;
  logic [5:0] iss_slot;
  logic [7:0] iss_tag;
  logic [11:0] iss_seq;
  logic [4:0] ret_dst0, ret_dst1;

  int checks = 0, errors = 0, exp_seq = 0;
  int exp_q[$];
  bit done_flag = 0;

  ruu_queue dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic begin_cyc();
    @(negedge clk);
    disp_valid = 0; disp_ea = 0; disp_src = {3{NA}}; disp_src_rdy = 0;
    disp_dst0 = NA; disp_dst1 = NA; wb_valid = 0; wb_slot = 0; wb_tag = 0;
    wb_dst = NA; squash_valid = 0; squash_seq = 0;
  endtask

  task automatic settle();
    #(CLK_P/2 - 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin begin_cyc(); settle(); end
  endtask

  task automatic drv_disp(input logic [4:0] s0, input logic [4:0] d0, input logic ea);
    disp_valid = 1; disp_src = {NA, NA, s0}; disp_dst0 = d0; disp_ea = ea;
    if (disp_ready) begin
      exp_q.push_back(exp_seq * 256 + int'(d0));
      exp_seq++;
    end
  endtask

  task automatic drv_wb(input int slot, input int tag, input logic [4:0] d);
    wb_valid = 1; wb_slot = 3'(slot); wb_tag = 4'(tag); wb_dst = d;
  endtask

  task automatic drv_sq(input int seq);
    squash_valid = 1; squash_seq = 6'(seq);
    while (exp_q.size() > 0 && exp_q[$] / 256 > seq) void'(exp_q.pop_back());
    exp_seq = seq + 1;
  endtask

  // scoreboard monitor: retirement order (R6)
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n && ret_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected retire seq", int'(ret_seq), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk("R6 retire seq", int'(ret_seq), e / 256);
        chk("R6 retire dst", int'(ret_dst0), e % 256);
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    begin_cyc();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    begin_cyc(); settle();
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 ret_valid", ret_valid, 0);
    chk("R1 ea_wake", ea_wake, 0);
    chk("R1 disp_slot", disp_slot, 0);
    chk("R1 disp_seq", disp_seq, 0);
    // R2 / R3
    begin_cyc(); drv_disp(NA, 5'd3, 0); settle();
    begin_cyc(); drv_disp(5'd3, 5'd4, 0); settle();
    chk("R2 issue lane0", iss_valid, 1);
    chk("R2 issue slot", iss_slot[2:0], 0);
    chk("R2 issue seq", iss_seq[5:0], 0);
    chk("R2 disp_slot", disp_slot, 1);
    chk("R2 disp_seq", disp_seq, 1);
    begin_cyc(); drv_wb(5, 0, 5'd9); settle();
    chk("R3 pending not offered", iss_valid, 0);
    begin_cyc(); settle();
    chk("R3 foreign name no wake", iss_valid, 0);
    chk("R5 invalid slot no complete", ret_valid, 0);
    begin_cyc(); drv_wb(0, 0, 5'd3); settle();
    begin_cyc(); settle();
    chk("R3 woken issue", iss_valid, 1);
    chk("R3 woken slot", iss_slot[2:0], 1);
    begin_cyc(); drv_wb(1, 0, 5'd4); settle();
    idle(2);
    // R4 / R10 / R9 / R6
    begin_cyc(); drv_disp(NA, 5'd12, 0); settle();
    begin_cyc(); drv_disp(5'd12, 5'd5, 0); settle();
    chk("R2 producer slot", iss_slot[2:0], 2);
    begin_cyc(); drv_disp(5'd12, 5'd6, 1); settle();
    begin_cyc(); drv_disp(5'd12, 5'd7, 0); settle();
    begin_cyc(); drv_wb(2, 0, 5'd12); drv_disp(5'd12, 5'd8, 0); settle();
    begin_cyc(); settle();
    chk("R4 two lanes", iss_valid, 3);
    chk("R4 lane0 oldest", iss_slot[2:0], 3);
    chk("R4 lane1 next", iss_slot[5:3], 4);
    begin_cyc(); settle();
    chk("R4 remaining lanes", iss_valid, 3);
    chk("R4 lane0 slot", iss_slot[2:0], 5);
    chk("R10 bypassed entry", iss_slot[5:3], 6);
    begin_cyc(); drv_wb(5, 0, NA); settle();
    begin_cyc(); settle();
    chk("R6 head not done", ret_valid, 0);
    begin_cyc(); drv_wb(4, 0, NA); settle();
    chk("R9 ea_wake", ea_wake, 1);
    chk("R9 ea_wake_seq", ea_wake_seq, 4);
    begin_cyc(); drv_wb(3, 0, NA); settle();
    chk("R9 no ea_wake", ea_wake, 0);
    begin_cyc(); drv_wb(6, 0, NA); settle();
    idle(4);
    // R7
    for (int k = 0; k < 8; k++) begin
      begin_cyc(); drv_disp(5'd20, 5'(10 + k), 0); settle();
    end
    begin_cyc(); drv_disp(5'd20, 5'd30, 0); settle();
    chk("R7 full", disp_ready, 0);
    // R8
    begin_cyc(); drv_sq(9); settle();
    chk("R7 seq held", disp_seq, 15);
    begin_cyc(); settle();
    chk("R8 ready again", disp_ready, 1);
    chk("R8 tail slot", disp_slot, 2);
    chk("R8 next seq", disp_seq, 10);
    begin_cyc(); drv_disp(NA, 5'd25, 0); settle();
    begin_cyc(); settle();
    chk("R8 new entry slot", iss_slot[2:0], 2);
    chk("R5 bumped tag", iss_tag[3:0], 1);
    chk("R8 new entry seq", iss_seq[5:0], 10);
    begin_cyc(); drv_wb(2, 0, 5'd20); settle();
    begin_cyc(); settle();
    chk("R5 stale no wake", iss_valid, 0);
    chk("R6 head not done after stale", ret_valid, 0);
    begin_cyc(); drv_wb(2, 1, 5'd20); settle();
    begin_cyc(); settle();
    chk("R4 wrap lanes", iss_valid, 3);
    chk("R4 wrap lane0", iss_slot[2:0], 7);
    chk("R4 wrap lane1", iss_slot[5:3], 0);
    begin_cyc(); settle();
    chk("R4 last lane", iss_slot[2:0], 1);
    begin_cyc(); drv_wb(7, 0, NA); settle();
    begin_cyc(); drv_wb(0, 0, NA); settle();
    begin_cyc(); drv_wb(1, 0, NA); settle();
    idle(6);
    chk("R6 all retired", exp_q.size(), 0);
    finish_run();
  end
endmodule